// File: doc/BRIEF.md
# Boost and Current Duty Controller

This block sits between the sampling front end of a single-phase grid-tied inverter with a boost stage and the gate sequencer. Once per switching period, a start strobe tells it to capture its measurements. Those are the input voltage, the second storage capacitor voltage and the signed grid current. It also captures the rectified grid-angle sine, the peak link-voltage target, the grid peak voltage, the peak current target and a reciprocal of the link target that was computed beforehand. It then returns two duty words: the shoot-through duty, and the combined duty for the main switch of the active half-cycle.

Each duty is a feed-forward nominal value plus a feedback correction.

- **Shoot-through duty:** the nominal part is the capacitor voltage over the link target. The correction is a PI loop on a derived capacitor-voltage target, because the link voltage itself pulses. The integrator has clamped limits.
- **Sinusoidal duty:** the nominal part is the grid peak times the sine over the link target. The correction is proportional to the current error.

All arithmetic is signed fixed point with saturation. Duties use DF fraction bits, so 1.0 is 2^DF. The sine uses SF fraction bits. The divisions by the link target are multiplications by the reciprocal input followed by a right shift of RSH.

Top module: `qzs_duty_ctrl`

## Requirements
- R1: While reset is active and after it is released, both duty outputs are 0 and `duty_vld` is low until the first result.
- R2: Inputs are captured only in the cycle `start` is high. `duty_vld` is high for exactly one cycle, three clock edges after the edge that samples `start`. The duty outputs change only in that cycle and hold otherwise. Starts may come on consecutive cycles.
- R3: The capacitor target is (vlink_ref − vin) >>> 1, using an arithmetic shift. The voltage error is that target minus vc2.
- R4: The nominal shoot-through duty is (vc2 × link_recip) >>> RSH.
- R5: The voltage correction is (KP × error + acc) >>> GSH. Here acc is the integrator after this period's update acc + KI × error. The correction is added to the nominal shoot-through duty.
- R6: The integrator is clamped to the range −ACC_LIM … +ACC_LIM.
- R7: The shoot-through duty is saturated to the range 0 … 2^(DF−1) − 1, which keeps it below 0.5.
- R8: The current target is (ipk_ref × sine) >>> SF. The current correction is (KG × (target − |ig|)) >>> GSH.
- R9: The nominal sinusoidal duty is (((vgrid_pk × sine) >>> SF) × link_recip) >>> RSH. After the current correction is added, it is saturated to the range 0 … 2^DF.
- R10: `duty_sw` is the saturated sinusoidal duty plus the shoot-through duty, capped at 2^DF.
- R11: At the nominal point, with vin 250, vlink_ref 500, vc2 125, link_recip 4294968 and an empty integrator, `duty_st` is 8192 (0.25).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Period-boundary strobe |
| vin | input | VW | Input voltage, signed |
| vc2 | input | VW | Capacitor voltage, signed |
| ig | input | VW | Grid current, signed |
| sine | input | SF+1 | Rectified sine, unsigned, 2^SF = 1.0 |
| vlink_ref | input | VW | Peak link-voltage target, signed |
| vgrid_pk | input | VW | Grid peak voltage, signed |
| ipk_ref | input | VW | Peak current target, signed |
| link_recip | input | RW | 2^(DF+RSH) / vlink_ref, rounded up, unsigned |
| duty_st | output | DF+1 | Shoot-through duty |
| duty_sw | output | DF+1 | Combined main-switch duty |
| duty_vld | output | 1 | One-cycle result strobe |

## Verification
The bench uses the default widths and gains, except KI = 16 and ACC_LIM = 4000. With those values, a constant voltage error of 100 reaches the integrator clamp on the third period, so both the growth of the integrator and its limit are exercised. The stimulus covers several further cases:
- the nominal point;
- shoot-through saturation at both ends;
- a sinusoidal duty that overshoots 1.0 on its own;
- a sum of the two duties that overshoots 1.0;
- back-to-back start strobes;
- scrambling of the inputs between strobes.

// File: rtl/qzs_duty_pkg.sv
package qzs_duty_pkg;
  localparam int PW = 48;
  typedef logic signed [PW-1:0] wide_t;

  function automatic wide_t clip(input wide_t x, input wide_t lo, input wide_t hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction
endpackage

// File: rtl/qdc_front.sv
// Stage 1: capture at start, form the capacitor target, the errors and the grid-peak-times-sine term.
module qdc_front
  import qzs_duty_pkg::*;
#(
  parameter int VW = 16,
  parameter int SF = 15,
  parameter int RW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [VW-1:0] vin,
  input  logic signed [VW-1:0] vc2,
  input  logic signed [VW-1:0] ig,
  input  logic        [SF:0]   sine,
  input  logic signed [VW-1:0] vlink_ref,
  input  logic signed [VW-1:0] vgrid_pk,
  input  logic signed [VW-1:0] ipk_ref,
  input  logic        [RW-1:0] link_recip,
  output wide_t                err_v,
  output wide_t                err_i,
  output wide_t                vc2_w,
  output wide_t                vg_sin,
  output wide_t                recip_w,
  output logic                 vld
);
  wide_t err_v_d, err_i_d, vc2_d, vgs_d, rcp_d;
  wide_t cap_ref, i_ref, ig_w, ig_abs;

  always_comb begin
    cap_ref = (wide_t'(vlink_ref) - wide_t'(vin)) >>> 1;
    err_v_d = cap_ref - wide_t'(vc2);
    i_ref   = (wide_t'(ipk_ref) * wide_t'(sine)) >>> SF;
    ig_w    = wide_t'(ig);
    ig_abs  = (ig_w < 0) ? -ig_w : ig_w;
    err_i_d = i_ref - ig_abs;
    vgs_d   = (wide_t'(vgrid_pk) * wide_t'(sine)) >>> SF;
    vc2_d   = wide_t'(vc2);
    rcp_d   = wide_t'(link_recip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_v   <= '0;
      err_i   <= '0;
      vc2_w   <= '0;
      vg_sin  <= '0;
      recip_w <= '0;
      vld     <= 1'b0;
    end else begin
      vld <= start;
      if (start) begin
        err_v   <= err_v_d;
        err_i   <= err_i_d;
        vc2_w   <= vc2_d;
        vg_sin  <= vgs_d;
        recip_w <= rcp_d;
      end
    end
  end
endmodule

// File: rtl/qdc_loops.sv
// Stage 2: nominal terms via reciprocal, clamped PI on voltage, P on current.
module qdc_loops
  import qzs_duty_pkg::*;
#(
  parameter int RSH     = 16,
  parameter int GSH     = 8,
  parameter int KP      = 64,
  parameter int KI      = 8,
  parameter int KG      = 32,
  parameter int ACC_LIM = 1 << 20
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  wide_t err_v,
  input  wide_t err_i,
  input  wide_t vc2_w,
  input  wide_t vg_sin,
  input  wide_t recip_w,
  output wide_t nom_st,
  output wide_t nom_sp,
  output wide_t vcor,
  output wide_t icor,
  output wide_t acc,
  output logic  vld
);
  localparam wide_t ACC_HI = wide_t'(ACC_LIM);
  localparam wide_t ACC_LO = -wide_t'(ACC_LIM);

  wide_t nom_st_d, nom_sp_d, vcor_d, icor_d, acc_d;

  always_comb begin
    nom_st_d = (vc2_w * recip_w) >>> RSH;
    nom_sp_d = (vg_sin * recip_w) >>> RSH;
    acc_d    = clip(acc + wide_t'(KI) * err_v, ACC_LO, ACC_HI);
    vcor_d   = (wide_t'(KP) * err_v + acc_d) >>> GSH;
    icor_d   = (wide_t'(KG) * err_i) >>> GSH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nom_st <= '0;
      nom_sp <= '0;
      vcor   <= '0;
      icor   <= '0;
      acc    <= '0;
      vld    <= 1'b0;
    end else begin
      vld <= en;
      if (en) begin
        nom_st <= nom_st_d;
        nom_sp <= nom_sp_d;
        vcor   <= vcor_d;
        icor   <= icor_d;
        acc    <= acc_d;
      end
    end
  end
endmodule

// File: rtl/qdc_out.sv
// Stage 3: saturate each duty, sum and cap, hold until next result.
module qdc_out
  import qzs_duty_pkg::*;
#(
  parameter int DF = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  wide_t       nom_st,
  input  wide_t       nom_sp,
  input  wide_t       vcor,
  input  wide_t       icor,
  output logic [DF:0] duty_st,
  output logic [DF:0] duty_sw,
  output logic        vld
);
  localparam wide_t ONE    = wide_t'(1) <<< DF;
  localparam wide_t ST_TOP = (ONE >>> 1) - 1;

  wide_t st_c, sp_c, sw_c;

  always_comb begin
    st_c = clip(nom_st + vcor, '0, ST_TOP);
    sp_c = clip(nom_sp + icor, '0, ONE);
    sw_c = clip(st_c + sp_c, '0, ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_st <= '0;
      duty_sw <= '0;
      vld     <= 1'b0;
    end else begin
      vld <= en;
      if (en) begin
        duty_st <= st_c[DF:0];
        duty_sw <= sw_c[DF:0];
      end
    end
  end
endmodule

// File: rtl/qzs_duty_ctrl.sv
module qzs_duty_ctrl
  import qzs_duty_pkg::*;
#(
  parameter int VW      = 16,
  parameter int SF      = 15,
  parameter int DF      = 15,
  parameter int RW      = 24,
  parameter int RSH     = 16,
  parameter int GSH     = 8,
  parameter int KP      = 64,
  parameter int KI      = 8,
  parameter int KG      = 32,
  parameter int ACC_LIM = 1 << 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [VW-1:0] vin,
  input  logic signed [VW-1:0] vc2,
  input  logic signed [VW-1:0] ig,
  input  logic        [SF:0]   sine,
  input  logic signed [VW-1:0] vlink_ref,
  input  logic signed [VW-1:0] vgrid_pk,
  input  logic signed [VW-1:0] ipk_ref,
  input  logic        [RW-1:0] link_recip,
  output logic        [DF:0]   duty_st,
  output logic        [DF:0]   duty_sw,
  output logic                 duty_vld
);
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  wide_t err_v, err_i, vc2_w, vg_sin, recip_w;
  wide_t nom_st, nom_sp, vcor, icor, integ_acc;
  logic  s1_vld, s2_vld;

  qdc_front #(.VW(VW), .SF(SF), .RW(RW)) u_front (
    .clk(clk), .rst_n(rst_int_n), .start(start),
    .vin(vin), .vc2(vc2), .ig(ig), .sine(sine),
    .vlink_ref(vlink_ref), .vgrid_pk(vgrid_pk), .ipk_ref(ipk_ref),
    .link_recip(link_recip),
    .err_v(err_v), .err_i(err_i), .vc2_w(vc2_w), .vg_sin(vg_sin),
    .recip_w(recip_w), .vld(s1_vld)
  );

  qdc_loops #(.RSH(RSH), .GSH(GSH), .KP(KP), .KI(KI), .KG(KG),
              .ACC_LIM(ACC_LIM)) u_loops (
    .clk(clk), .rst_n(rst_int_n), .en(s1_vld),
    .err_v(err_v), .err_i(err_i), .vc2_w(vc2_w), .vg_sin(vg_sin),
    .recip_w(recip_w),
    .nom_st(nom_st), .nom_sp(nom_sp), .vcor(vcor), .icor(icor),
    .acc(integ_acc), .vld(s2_vld)
  );

  qdc_out #(.DF(DF)) u_out (
    .clk(clk), .rst_n(rst_int_n), .en(s2_vld),
    .nom_st(nom_st), .nom_sp(nom_sp), .vcor(vcor), .icor(icor),
    .duty_st(duty_st), .duty_sw(duty_sw), .vld(duty_vld)
  );
endmodule

// File: rtl/qdc_checker.sv
module qdc_checker
  import qzs_duty_pkg::*;
#(
  parameter int DF      = 15,
  parameter int ACC_LIM = 1 << 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [DF:0] duty_st,
  input logic [DF:0] duty_sw,
  input logic        duty_vld,
  input wide_t       acc
);
  localparam int ONE = 1 << DF;

  // R2: result strobe exactly three edges after the sampled start
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld |-> $past(start, 3));
  a_r2_every_start: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start, 3) |-> duty_vld);
  // R2: outputs hold between results
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_vld |-> ($stable(duty_st) && $stable(duty_sw)));
  // R6: integrator stays inside its clamp
  a_r6_acc_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (acc <= wide_t'(ACC_LIM)) && (acc >= -wide_t'(ACC_LIM)));
  // R7: shoot-through duty below one half
  a_r7_st_below_half: assert property (@(posedge clk) disable iff (!rst_n)
    int'(duty_st) < ONE / 2);
  // R10: combined duty capped and never below the shoot-through part
  a_r10_sw_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(duty_sw) <= ONE);
  a_r10_sw_ge_st: assert property (@(posedge clk) disable iff (!rst_n)
    duty_sw >= duty_st);
endmodule

bind qzs_duty_ctrl qdc_checker #(.DF(DF), .ACC_LIM(ACC_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .duty_st(duty_st),
  .duty_sw(duty_sw), .duty_vld(duty_vld), .acc(integ_acc)
);

// File: tb/qzs_duty_ctrl_tb.sv
module qzs_duty_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 16, SF = 15, DF = 15, RW = 24, RSH = 16, GSH = 8;
  localparam int KP = 64, KI = 16, KG = 32, ACC_LIM = 4000;
  localparam longint ONE = 64'sd1 << DF;
  localparam int RCP = 4294968;

  logic clk, rst_n, start;
  logic signed [VW-1:0] vin, vc2, ig, vlink_ref, vgrid_pk, ipk_ref;
  logic [SF:0] sine;
  logic [RW-1:0] link_recip;
  logic [DF:0] duty_st, duty_sw;
  logic duty_vld;

  qzs_duty_ctrl #(.VW(VW), .SF(SF), .DF(DF), .RW(RW), .RSH(RSH), .GSH(GSH),
                  .KP(KP), .KI(KI), .KG(KG), .ACC_LIM(ACC_LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vin(vin), .vc2(vc2), .ig(ig),
    .sine(sine), .vlink_ref(vlink_ref), .vgrid_pk(vgrid_pk), .ipk_ref(ipk_ref),
    .link_recip(link_recip), .duty_st(duty_st), .duty_sw(duty_sw),
    .duty_vld(duty_vld)
  );

  typedef struct { longint st; longint sw; int cyc; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  longint mdl_acc = 0;
  int last_st = 0, last_sw = 0;
  bit mon_on = 0;

  initial clk = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint lim(longint x, longint lo, longint hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Drives one period; the expected result follows the requirement formulas.
  task automatic drive(string tag, int a_vin, int a_vc2, int a_ig, int a_sine,
                       int a_vlr, int a_vgp, int a_ipk, int gap);
    exp_t e;
    longint ev, nst, vc, st, iref, ei, ic, vgs, nsp, sp;
    ev   = ((longint'(a_vlr) - a_vin) >>> 1) - a_vc2;                 // R3
    nst  = (longint'(a_vc2) * RCP) >>> RSH;                            // R4
    mdl_acc = lim(mdl_acc + KI * ev, -ACC_LIM, ACC_LIM);               // R6
    vc   = (KP * ev + mdl_acc) >>> GSH;                                // R5
    st   = lim(nst + vc, 0, ONE / 2 - 1);                              // R7
    iref = (longint'(a_ipk) * a_sine) >>> SF;                          // R8
    ei   = iref - ((a_ig < 0) ? -a_ig : a_ig);
    ic   = (KG * ei) >>> GSH;
    vgs  = (longint'(a_vgp) * a_sine) >>> SF;                          // R9
    nsp  = (vgs * RCP) >>> RSH;
    sp   = lim(nsp + ic, 0, ONE);
    e.st = st;
    e.sw = lim(sp + st, 0, ONE);                                       // R10
    e.cyc = cyc + 3;
    e.tag = tag;
    vin = VW'(a_vin); vc2 = VW'(a_vc2); ig = VW'(a_ig); sine = (SF+1)'(a_sine);
    vlink_ref = VW'(a_vlr); vgrid_pk = VW'(a_vgp); ipk_ref = VW'(a_ipk);
    link_recip = RW'(RCP);
    start = 1'b1;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    // R2: inputs outside the start cycle must be ignored
    vin = 16'sd7777; vc2 = -16'sd3000; ig = 16'sd999; sine = '1;
    vlink_ref = 16'sd1; vgrid_pk = 16'sd12345; ipk_ref = -16'sd500;
    link_recip = '1;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (mon_on) begin
      if (duty_vld) begin
        if (q.size() == 0) begin
          chk("R2 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " R2 latency"}, cyc, e.cyc);
          chk({e.tag, " duty_st"}, duty_st, e.st);
          chk({e.tag, " duty_sw"}, duty_sw, e.sw);
          last_st = duty_st;
          last_sw = duty_sw;
        end
      end else begin
        chk("R2 hold st", duty_st, last_st);
        chk("R2 hold sw", duty_sw, last_sw);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; start = 0;
    vin = '0; vc2 = '0; ig = '0; sine = '0; vlink_ref = '0; vgrid_pk = '0;
    ipk_ref = '0; link_recip = '0;
    repeat (5) @(negedge clk);
    chk("R1 reset st", duty_st, 0);
    chk("R1 reset sw", duty_sw, 0);
    chk("R1 reset vld", duty_vld, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release vld", duty_vld, 0);
    mon_on = 1;

    // R11 nominal point, R3 R4 zero error
    drive("R11 R4 R3 nominal", 250, 125, 0, 0, 500, 0, 0, 5);
    chk("R11 st is 0.25", last_st, 8192);
    // R9 R10 feed-forward sine, zero current error
    drive("R9 R10 half sine", 250, 125, -5, 16384, 500, 311, 10, 4);
    // R8 current error correction
    drive("R8 current error", 250, 125, 0, 32768, 500, 100, 100, 4);
    drive("R8 negative correction clipped R9", 250, 125, -200, 0, 500, 0, 0, 4);
    // R5 R6 integrator growth and clamp (back-to-back starts, R2)
    drive("R5 integ 1", 250, 25, 0, 0, 500, 0, 0, 0);
    drive("R5 integ 2", 250, 25, 0, 0, 500, 0, 0, 0);
    drive("R6 integ clamp", 250, 25, 0, 0, 500, 0, 0, 4);
    drive("R6 held at clamp", 250, 25, 0, 0, 500, 0, 0, 4);
    // R7 shoot-through saturation high and low
    drive("R7 sat high", 0, 4000, 0, 0, 500, 0, 0, 4);
    drive("R7 sat low", 250, -100, 0, 0, 500, 0, 0, 4);
    // R10 combined cap: sine term alone over 1.0, then only the sum
    drive("R9 R10 spwm over one", 250, 125, 0, 32768, 500, 600, 0, 4);
    drive("R10 sum over one", 250, 125, 0, 32768, 500, 400, 0, 4);
    drive("R3 odd difference", 251, 120, 7, 20000, 500, 200, 30, 6);
    chk("R2 all results seen", q.size(), 0);
    finish_run();
  end
endmodule